// File: doc/BRIEF.md
# Set-Associative Data Cache Controller with Selectable Write Policy

This block is a data cache placed between a processor load/store port and a slower next-level memory. Each word address is split into a line offset (low bits), a set index (the next bits, so that the set is the line address modulo the number of sets) and a tag (the remaining upper bits). On every request the controller compares the tag against the stored tag of every valid way in the indexed set. A hit completes at once. A miss holds the requester while a whole line is fetched one word at a time, in rising offset order, from the next level. The victim way is the one unused for the longest time.

A build-time parameter selects one of two write policies. With `WRITE_BACK=1`, stores update only the cache and mark the line dirty, write misses allocate the line before writing, and a dirty victim is copied out word by word before its slot is refilled. With `WRITE_BACK=0`, every store is sent to the next level, a store that hits also updates the cached word, and a store that misses leaves the cache untouched.

Requester protocol: `cpu_req` is raised with address, direction and write data and held until `cpu_done` is high for one cycle. Memory protocol: `mem_req` is held with stable address, direction and data until `mem_ack` is high for one cycle; read data arrives on `mem_rdata` alongside `mem_ack`.

Top module: `wpcache_ctrl`

## Requirements
- R1: The set index is address bits [OFF_W+IDX_W-1:OFF_W] and the offset is bits [OFF_W-1:0]; lines with the same tag in different sets do not displace each other.
- R2: After reset no line is valid: the first access to any line is reported as a miss, and `cpu_done` and `mem_req` are low while reset is held.
- R3: A read hit raises `cpu_done` with `cpu_hit`=1 in the cycle the request is seen by an idle controller, returns the stored word and starts no memory transfer.
- R4: A read miss issues exactly LINE_WORDS next-level reads for the missing line, then completes with `cpu_hit`=0 and the word at the requested address.
- R5: On a miss in a full set the victim is the way whose last hit or fill is oldest; hits and fills both refresh a way.
- R6: With WRITE_BACK=1 a store hit updates the cache only, with no memory transfer, and marks the line dirty.
- R7: With WRITE_BACK=1 a dirty victim is written out as LINE_WORDS next-level writes of its current contents before any fill read; a clean victim causes no write.
- R8: With WRITE_BACK=1 a store miss fills the line first (LINE_WORDS reads) and then completes as a cache write with `cpu_hit`=0.
- R9: With WRITE_BACK=0 every store causes exactly one next-level write carrying the request address and data; on a hit the cached word is updated too and `cpu_hit`=1.
- R10: With WRITE_BACK=0 a store miss performs no fill and leaves the set contents and order unchanged.
- R11: While `mem_req` is high and `mem_ack` has not arrived, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged.
- R12: `cpu_done` is high only while `cpu_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Access request, held until done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Store data |
| cpu_done | output | 1 | Access complete this cycle |
| cpu_hit | output | 1 | Access was served without a fill |
| cpu_rdata | output | WORD_W | Load data, valid with cpu_done |
| mem_req | output | 1 | Next-level transfer request |
| mem_we | output | 1 | 1 = next-level write |
| mem_addr | output | ADDR_W | Next-level word address |
| mem_wdata | output | WORD_W | Next-level write data |
| mem_ack | input | 1 | Transfer accepted / read data valid |
| mem_rdata | input | WORD_W | Next-level read data |

## Verification
The assertions assume that the requester keeps `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady from the raise until the cycle after `cpu_done`, and that the next level raises `mem_ack` only for a pending `mem_req` and for one cycle at a time. The bench drives one access at a time per controller, drops the request only after the edge that consumed `cpu_done`, and its memory responder acknowledges each request after a fixed latency with a one-cycle pulse. Directed sequences hit each policy corner (cold miss, conflict in one set, dirty and clean eviction, store miss), followed by a pseudo-random mix of loads and stores confined to a small address range so that hits, evictions and refills recur.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_STORE = 2'd3
  } wpc_state_e;
endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
  parameter int NUM_WAYS = 2,
  parameter int NUM_SETS = 4,
  parameter int TAG_W    = 8,
  parameter int IDX_W    = 2,
  parameter int WAY_W    = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [IDX_W-1:0]                lk_idx,
  input  logic [TAG_W-1:0]                lk_tag,
  input  logic                            fill_en,
  input  logic [WAY_W-1:0]                fill_way,
  input  logic                            dset_en,
  input  logic [WAY_W-1:0]                dset_way,
  input  logic                            dclr_en,
  input  logic [WAY_W-1:0]                dclr_way,
  output logic [NUM_WAYS-1:0]             hit_vec,
  output logic [NUM_WAYS-1:0]             valid_vec,
  output logic [NUM_WAYS-1:0]             dirty_vec,
  output logic [NUM_WAYS-1:0][TAG_W-1:0]  tag_vec
);
  logic [NUM_SETS-1:0] valid_q [NUM_WAYS];
  logic [NUM_SETS-1:0] dirty_q [NUM_WAYS];
  logic [TAG_W-1:0]    tag_q   [NUM_WAYS][NUM_SETS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic fill_me, dset_me, dclr_me;
    assign fill_me = fill_en && (fill_way == WAY_W'(w));
    assign dset_me = dset_en && (dset_way == WAY_W'(w));
    assign dclr_me = dclr_en && (dclr_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[w] <= '0;
        dirty_q[w] <= '0;
      end else begin
        if (fill_me) begin
          valid_q[w][lk_idx] <= 1'b1;
          dirty_q[w][lk_idx] <= 1'b0;
        end
        if (dset_me) dirty_q[w][lk_idx] <= 1'b1;
        if (dclr_me) dirty_q[w][lk_idx] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_me) tag_q[w][lk_idx] <= lk_tag;
    end

    assign valid_vec[w] = valid_q[w][lk_idx];
    assign dirty_vec[w] = dirty_q[w][lk_idx];
    assign tag_vec[w]   = tag_q[w][lk_idx];
    assign hit_vec[w]   = valid_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag);
  end
endmodule

// File: rtl/wpc_lru.sv
module wpc_lru #(
  parameter int NUM_WAYS = 2,
  parameter int NUM_SETS = 4,
  parameter int IDX_W    = 2,
  parameter int WAY_W    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(NUM_WAYS - 1);

  // Per-set age per way; ages form a permutation, 0 = most recent.
  logic [WAY_W-1:0] age_q [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0] touched_age;

  assign touched_age = age_q[idx][touch_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[idx][w] <= '0;
        else if (age_q[idx][w] < touched_age)
          age_q[idx][w] <= age_q[idx][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (age_q[idx][w] == OLDEST) victim_way = WAY_W'(w);
  end
endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store #(
  parameter int WORD_W     = 32,
  parameter int NUM_WAYS   = 2,
  parameter int NUM_SETS   = 4,
  parameter int LINE_WORDS = 4,
  parameter int WAY_W      = 1,
  parameter int IDX_W      = 2,
  parameter int OFF_W      = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [WORD_W-1:0] rd_data
);
  localparam int LOC_W = WAY_W + IDX_W + OFF_W;
  localparam int DEPTH = 1 << LOC_W;

  logic [WORD_W-1:0] word_q [DEPTH];
  logic [LOC_W-1:0]  wr_loc, rd_loc;

  assign wr_loc = {wr_way, idx, wr_off};
  assign rd_loc = {rd_way, idx, rd_off};

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_loc] <= wr_data;
  end

  assign rd_data = word_q[rd_loc];
endmodule

// File: rtl/wpcache_ctrl.sv
module wpcache_ctrl
  import wpc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_SETS   = 4,
  parameter int NUM_WAYS   = 2,
  parameter int WRITE_BACK = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int  OFF_W = $clog2(LINE_WORDS);
  localparam int  IDX_W = $clog2(NUM_SETS);
  localparam int  TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int  WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam bit  WB    = (WRITE_BACK != 0);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_WORDS - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // Address fields
  logic [OFF_W-1:0] a_off;
  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag;
  assign a_off = cpu_addr[OFF_W-1:0];
  assign a_idx = cpu_addr[OFF_W +: IDX_W];
  assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  // State
  wpc_state_e       state_q, state_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;
  logic [WAY_W-1:0] vic_q, vic_d;
  logic             miss_q, miss_d;

  // Lookup and update wiring
  logic [NUM_WAYS-1:0]            hit_vec, valid_vec, dirty_vec;
  logic [NUM_WAYS-1:0][TAG_W-1:0] tag_vec;
  logic                           hit;
  logic [WAY_W-1:0]               hit_way, lru_victim;
  logic                           fill_en, dset_en, dclr_en, touch_en;
  logic [WAY_W-1:0]               touch_way;
  logic                           dw_en;
  logic [WAY_W-1:0]               dw_way, dr_way;
  logic [OFF_W-1:0]               dw_off, dr_off;
  logic [WORD_W-1:0]              dw_data, dr_data;

  wpc_tag_store #(
    .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .TAG_W(TAG_W),
    .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_ni), .lk_idx(a_idx), .lk_tag(a_tag),
    .fill_en(fill_en), .fill_way(vic_q),
    .dset_en(dset_en), .dset_way(hit_way),
    .dclr_en(dclr_en), .dclr_way(vic_q),
    .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
    .tag_vec(tag_vec)
  );

  wpc_lru #(
    .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_lru (
    .clk(clk), .rst_n(rst_ni), .idx(a_idx),
    .touch_en(touch_en), .touch_way(touch_way), .victim_way(lru_victim)
  );

  wpc_data_store #(
    .WORD_W(WORD_W), .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS),
    .LINE_WORDS(LINE_WORDS), .WAY_W(WAY_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) u_data (
    .clk(clk), .wr_en(dw_en), .wr_way(dw_way), .idx(a_idx),
    .wr_off(dw_off), .wr_data(dw_data),
    .rd_way(dr_way), .rd_off(dr_off), .rd_data(dr_data)
  );

  assign hit = |hit_vec;
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign dr_way    = (state_q == ST_EVICT) ? vic_q : hit_way;
  assign dr_off    = (state_q == ST_EVICT) ? cnt_q : a_off;
  assign cpu_rdata = dr_data;

  // Next-state process
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    vic_d     = vic_q;
    miss_d    = miss_q;
    cpu_done  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {a_tag, a_idx, cnt_q};
    mem_wdata = dr_data;
    fill_en   = 1'b0;
    dset_en   = 1'b0;
    dclr_en   = 1'b0;
    touch_en  = 1'b0;
    touch_way = hit_way;
    dw_en     = 1'b0;
    dw_way    = hit_way;
    dw_off    = a_off;
    dw_data   = cpu_wdata;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (cpu_we && !WB) begin
            state_d = ST_STORE;
          end else if (hit) begin
            cpu_done = 1'b1;
            touch_en = 1'b1;
            miss_d   = 1'b0;
            if (cpu_we) begin
              dw_en   = 1'b1;
              dset_en = 1'b1;
            end
          end else begin
            miss_d  = 1'b1;
            vic_d   = lru_victim;
            cnt_d   = '0;
            state_d = (WB && valid_vec[lru_victim] && dirty_vec[lru_victim])
                      ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {tag_vec[vic_q], a_idx, cnt_q};
        if (mem_ack) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_OFF) begin
            dclr_en = 1'b1;
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          dw_en   = 1'b1;
          dw_way  = vic_q;
          dw_off  = cnt_q;
          dw_data = mem_rdata;
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == LAST_OFF) begin
            fill_en   = 1'b1;
            touch_en  = 1'b1;
            touch_way = vic_q;
            state_d   = ST_IDLE;
          end
        end
      end
      ST_STORE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cpu_addr;
        mem_wdata = cpu_wdata;
        if (mem_ack) begin
          cpu_done = 1'b1;
          miss_d   = 1'b0;
          state_d  = ST_IDLE;
          if (hit) begin
            dw_en    = 1'b1;
            touch_en = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cpu_hit = cpu_done && ((state_q == ST_STORE) ? hit : !miss_q);

  // Register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vic_q   <= '0;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      vic_q   <= vic_d;
      miss_q  <= miss_d;
    end
  end
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int WRITE_BACK = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [WORD_W-1:0] cpu_wdata,
  input logic              cpu_done,
  input logic              cpu_hit,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_ack
);
  p_done_with_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> cpu_req);

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                               $stable(mem_addr) && $stable(mem_wdata)));

  p_read_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_hit && !cpu_we) |-> !mem_req);

  p_wb_store_hit_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK != 0 && cpu_done && cpu_hit && cpu_we) |-> !mem_req);

  p_fill_after_evict_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> !(mem_req && mem_we));

  p_wt_store_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITE_BACK == 0 && mem_req && mem_we) |->
      (mem_addr == cpu_addr && mem_wdata == cpu_wdata && cpu_req && cpu_we));
endmodule

bind wpcache_ctrl wpc_checker #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WRITE_BACK(WRITE_BACK)
) u_wpc_checker (
  .clk(clk), .rst_n(rst_n),
  .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_done(cpu_done), .cpu_hit(cpu_hit),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/wpcache_ctrl_test.sv
module wpcache_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12, WW = 32, LW = 4, NS = 4, NW = 2;
  localparam int OFFW = 2, IDXW = 2;

  logic clk;
  logic rst_n;
  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Index 0 = write-back controller, 1 = write-through controller
  logic [1:0]    creq, cdone, chit;
  logic          cwe;
  logic [AW-1:0] caddr;
  logic [WW-1:0] cwdata;
  logic [WW-1:0] crdata [2];
  logic [1:0]    mreq, mwe, mack;
  logic [AW-1:0] maddr [2];
  logic [WW-1:0] mwdata [2];
  logic [WW-1:0] mrdata [2];

  wpcache_ctrl #(.ADDR_W(AW), .WORD_W(WW), .LINE_WORDS(LW), .NUM_SETS(NS),
                 .NUM_WAYS(NW), .WRITE_BACK(1)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(creq[0]), .cpu_we(cwe), .cpu_addr(caddr),
    .cpu_wdata(cwdata), .cpu_done(cdone[0]), .cpu_hit(chit[0]), .cpu_rdata(crdata[0]),
    .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]), .mem_wdata(mwdata[0]),
    .mem_ack(mack[0]), .mem_rdata(mrdata[0]));

  wpcache_ctrl #(.ADDR_W(AW), .WORD_W(WW), .LINE_WORDS(LW), .NUM_SETS(NS),
                 .NUM_WAYS(NW), .WRITE_BACK(0)) uut_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(creq[1]), .cpu_we(cwe), .cpu_addr(caddr),
    .cpu_wdata(cwdata), .cpu_done(cdone[1]), .cpu_hit(chit[1]), .cpu_rdata(crdata[1]),
    .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]), .mem_wdata(mwdata[1]),
    .mem_ack(mack[1]), .mem_rdata(mrdata[1]));

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] seed_word(input int a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // Program-visible contents, and each controller's next-level memory
  logic [31:0] ref_arr [int];
  logic [31:0] mem_arr [2][int];
  int rd_cnt [2];
  int wr_cnt [2];
  int lat    [2];
  logic [AW-1:0] st_addr;
  logic [WW-1:0] st_data;

  function automatic logic [31:0] ref_word(input int a);
    return ref_arr.exists(a) ? ref_arr[a] : seed_word(a);
  endfunction

  // Next-level memory responder: fixed latency, one-cycle ack
  initial begin
    mack = '0;
    for (int g = 0; g < 2; g++) begin
      rd_cnt[g] = 0; wr_cnt[g] = 0; lat[g] = 0;
      mrdata[g] = '0;
    end
  end

  always @(posedge clk) begin
    for (int g = 0; g < 2; g++) begin
      mack[g] <= 1'b0;
      if (mreq[g] && !mack[g]) begin
        if (lat[g] == 1) begin
          lat[g]  <= 0;
          mack[g] <= 1'b1;
          if (mwe[g]) begin
            if (g == 1) begin
              chk(maddr[1] == st_addr, "R9 store address", 32'(maddr[1]), 32'(st_addr));
              chk(mwdata[1] == st_data, "R9 store data", mwdata[1], st_data);
            end else begin
              chk(mwdata[0] == ref_word(int'(maddr[0])), "R7 evicted word",
                  mwdata[0], ref_word(int'(maddr[0])));
            end
            mem_arr[g][int'(maddr[g])] <= mwdata[g];
            wr_cnt[g] <= wr_cnt[g] + 1;
          end else begin
            mrdata[g] <= mem_arr[g].exists(int'(maddr[g])) ? mem_arr[g][int'(maddr[g])]
                                                           : seed_word(int'(maddr[g]));
            rd_cnt[g] <= rd_cnt[g] + 1;
          end
        end else begin
          lat[g] <= lat[g] + 1;
        end
      end
    end
  end

  // Behavioural cache model: per set, tags in recency order (front = newest)
  int mtag   [2][NS][$];
  bit mdirty [2][NS][$];

  task automatic model(input int g, input bit we, input int addr,
                       output bit hit, output int exp_rd, output int exp_wr);
    int set, tag, pos;
    bit d;
    set = (addr >> OFFW) % NS;
    tag = addr >> (OFFW + IDXW);
    pos = -1;
    exp_rd = 0; exp_wr = 0;
    for (int i = 0; i < mtag[g][set].size(); i++)
      if (mtag[g][set][i] == tag) pos = i;
    if (pos >= 0) begin
      hit = 1;
      d = mdirty[g][set][pos];
      mtag[g][set].delete(pos);
      mdirty[g][set].delete(pos);
      mtag[g][set].push_front(tag);
      mdirty[g][set].push_front(d | (we && g == 0));
      if (we && g == 1) exp_wr = 1;
    end else begin
      hit = 0;
      if (we && g == 1) begin
        exp_wr = 1;
      end else begin
        if (mtag[g][set].size() == NW) begin
          if (mdirty[g][set][NW-1]) exp_wr = LW;
          void'(mtag[g][set].pop_back());
          void'(mdirty[g][set].pop_back());
        end
        exp_rd = LW;
        mtag[g][set].push_front(tag);
        mdirty[g][set].push_front(we && g == 0);
      end
    end
  endtask

  // One access applied to both controllers
  task automatic access(input bit we, input int addr, input logic [31:0] data, input string lbl);
    bit   exp_hit [2];
    int   exp_rd [2], exp_wr [2], rd0 [2], wr0 [2];
    bit   got [2];
    bit   got_hit [2];
    logic [31:0] got_data [2];
    logic [31:0] exp_data;
    bit   prev_hold [2];
    logic [AW-1:0] prev_addr [2];
    for (int g = 0; g < 2; g++) begin
      model(g, we, addr, exp_hit[g], exp_rd[g], exp_wr[g]);
      rd0[g] = rd_cnt[g]; wr0[g] = wr_cnt[g];
      got[g] = 0; prev_hold[g] = 0; prev_addr[g] = '0;
    end
    exp_data = ref_word(addr);
    st_addr = AW'(addr);
    st_data = data;
    cwe = we; caddr = AW'(addr); cwdata = data;
    creq = 2'b11;
    while (!(got[0] && got[1])) begin
      @(negedge clk);
      for (int g = 0; g < 2; g++) begin
        if (prev_hold[g])
          chk(mreq[g] && maddr[g] == prev_addr[g], "R11 request held",
              32'(maddr[g]), 32'(prev_addr[g]));
        prev_hold[g] = mreq[g] && !mack[g];
        prev_addr[g] = maddr[g];
        if (!creq[g] && cdone[g]) chk(0, "R12 done without request", 1, 0);
        if (creq[g] && cdone[g] && !got[g]) begin
          got[g] = 1; got_hit[g] = chit[g]; got_data[g] = crdata[g];
        end
      end
      @(posedge clk);
      #1;
      for (int g = 0; g < 2; g++) if (got[g]) creq[g] = 1'b0;
    end
    for (int g = 0; g < 2; g++) begin
      chk(got_hit[g] == exp_hit[g], $sformatf("%s hit flag (R5 order) mode%0d", lbl, g),
          32'(got_hit[g]), 32'(exp_hit[g]));
      if (!we)
        chk(got_data[g] == exp_data, $sformatf("R4 %s read data mode%0d", lbl, g),
            got_data[g], exp_data);
      chk(rd_cnt[g] - rd0[g] == exp_rd[g], $sformatf("R4 R8 R10 %s fill reads mode%0d", lbl, g),
          32'(rd_cnt[g] - rd0[g]), 32'(exp_rd[g]));
      chk(wr_cnt[g] - wr0[g] == exp_wr[g], $sformatf("R7 R9 %s memory writes mode%0d", lbl, g),
          32'(wr_cnt[g] - wr0[g]), 32'(exp_wr[g]));
    end
    if (we) ref_arr[addr] = data;
  endtask

  function automatic int mk(input int tag, input int idx, input int off);
    return (tag << (OFFW + IDXW)) | (idx << OFFW) | off;
  endfunction

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int lcg;
    creq = '0; cwe = 1'b0; caddr = '0; cwdata = '0;
    st_addr = '0; st_data = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      chk(cdone[g] == 1'b0, "R2 done low in reset", 32'(cdone[g]), 0);
      chk(mreq[g] == 1'b0, "R2 mem_req low in reset", 32'(mreq[g]), 0);
    end
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    access(0, mk(1,0,0), '0, "R2 cold miss");
    access(0, mk(1,0,3), '0, "R3 same line");
    access(0, mk(1,1,0), '0, "R1 other set");
    access(0, mk(1,0,1), '0, "R1 set kept");
    access(0, mk(2,0,0), '0, "R5 second way");
    access(0, mk(1,0,2), '0, "R5 refresh");
    access(0, mk(3,0,0), '0, "R5 evict oldest");
    access(0, mk(1,0,0), '0, "R5 refreshed kept");
    access(0, mk(2,0,0), '0, "R5 evicted refetch");
    access(1, mk(1,0,1), 32'hC0DE_0001, "R6 R9 store hit");
    access(0, mk(1,0,1), '0, "R6 R9 store readback");
    access(0, mk(5,0,0), '0, "R7 clean victim");
    access(0, mk(6,0,0), '0, "R7 dirty victim");
    access(0, mk(1,0,1), '0, "R7 written data back");
    access(1, mk(7,2,2), 32'hC0DE_0002, "R8 R10 store miss");
    access(0, mk(7,2,2), '0, "R8 R10 after store miss");
    access(0, mk(7,2,1), '0, "R8 R10 neighbour");

    lcg = 12345;
    for (int n = 0; n < 400; n++) begin
      int a;
      bit w;
      lcg = lcg * 1103515245 + 12345;
      a = (lcg >>> 8) & 8'hFF;
      w = ((lcg >>> 20) & 3) == 0;
      access(w, a, 32'(lcg), "R5 R6 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule